// File: doc/BRIEF.md
# Flag Offset Register Programming Controller

This block owns the four threshold offsets that a dual-FIFO device compares against its fill levels: an almost-empty and an almost-full offset for each FIFO, called Y1, X1, Y2 and X2 here. Master reset chooses how they are set. Three pins are sampled on every host clock edge while master reset is held low, and the value seen at the last such edge takes effect. The offsets can take a fixed preset, be written word by word from the host data bus, or be shifted in one bit per clock over a two-pin serial interface.

The two flag-select pins do two jobs. During master reset they encode the preset choice. Afterwards they act as an active-low serial enable and a serial data line. In serial mode the four registers form one shift chain of four times the offset width. A programmed flag reports when all four offsets hold their final values. From then on, further load cycles have no effect until the next master reset. Partial reset leaves the method, the offsets and any programming still in progress untouched.

Top module: `flagOffsetProg`

## Requirements
- R1: On every clock edge with `mrstN` low the method is taken from the pins. `modeSel` low selects serial load. With `modeSel` high, `{selHiSerEnN, selLoSerData}` = 00 selects preset 64, 01 selects preset 16, 10 selects preset 8 and 11 selects parallel load. The value sampled at the last low edge holds until the next master reset.
- R2: In a preset method, all four offsets equal the preset value and `progDone` is high from the first cycle after master reset is released.
- R3: In serial or parallel method, all four offsets are 0 and `progDone` is low while master reset is applied and after its release.
- R4: In serial method, a clock edge with `selHiSerEnN` low (and `prstN` high, `progDone` low) shifts `selLoSerData` into the LSB of X2. An edge with `selHiSerEnN` high changes nothing.
- R5: The serial chain is Y1, X1, Y2, X2, each filled MSB first, and is 4×OFS_W bits long. The first bit shifted ends in the MSB of Y1 and the last in the LSB of X2. `progDone` rises at the edge that takes the last bit.
- R6: In parallel method, successive `hostLoad` strobes write `hostOfs` into Y1, X1, Y2 and then X2. `progDone` rises at the fourth strobe.
- R7: Once `progDone` is high, serial bits and load strobes leave the offsets unchanged and `progDone` stays high until the next master reset.
- R8: While `prstN` is low, the offsets, the method, `progDone` and the programming progress are held, and serial bits and load strobes are ignored.
- R9: A new master reset re-selects the method and restarts programming, whatever state came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, rising edge active |
| mrstN | input | 1 | Master reset, active low, synchronous; method sampled while low |
| prstN | input | 1 | Partial reset, active low; holds all programming state |
| modeSel | input | 1 | Method pin: low serial, high preset or parallel |
| selHiSerEnN | input | 1 | Select bit 1 during reset; active-low serial enable afterwards |
| selLoSerData | input | 1 | Select bit 0 during reset; serial data afterwards |
| hostOfs | input | OFS_W | Low offset-width bits of the host data bus |
| hostLoad | input | 1 | Parallel word load strobe |
| ofsY1 | output | OFS_W | First FIFO almost-empty offset |
| ofsX1 | output | OFS_W | First FIFO almost-full offset |
| ofsY2 | output | OFS_W | Second FIFO almost-empty offset |
| ofsX2 | output | OFS_W | Second FIFO almost-full offset |
| progDone | output | 1 | All four offsets programmed |

## Verification
The bench shifts in a pattern with distinct bytes, so a chain in the wrong order or of the wrong direction scrambles the expected Y1/X1/Y2/X2 values. It checks the bit before the last so that an off-by-one counter, which raises `progDone` too early or too late, is caught. Serial enables and load strobes given during partial reset and after completion must leave the offsets unchanged. A design that leaks them would corrupt a word or advance its slot. Each preset code is walked in turn, and each reset starts from a different earlier state. This catches a swapped preset encoding and any method that survives a master reset.

// File: rtl/flagOffsetPkg.sv
`timescale 1ns/1ps
package flagOffsetPkg;

  typedef enum logic [1:0] {
    METH_SERIAL   = 2'd0,
    METH_PARALLEL = 2'd1,
    METH_PRESET   = 2'd2
  } methodT;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearAll;
    logic       loadPreset;
    logic [1:0] presetSel;
    logic       shiftIn;
    logic       wordWr;
    logic [1:0] wordIdx;
  } ofsStrbT;

  function automatic methodT decodeMethod(input logic modeSel, input logic [1:0] sel);
    if (!modeSel)        return METH_SERIAL;
    else if (sel == 2'b11) return METH_PARALLEL;
    else                 return METH_PRESET;
  endfunction

endpackage

// File: rtl/flagOffsetCtrl.sv
`timescale 1ns/1ps
module flagOffsetCtrl
  import flagOffsetPkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic    clk,
  input  logic    mrstN,
  input  logic    prstN,
  input  logic    modeSel,
  input  logic    selHiSerEnN,
  input  logic    selLoSerData,
  input  logic    hostLoad,
  output methodT  methodQ,
  output ofsStrbT strb,
  output logic    progDone
);
  localparam int CHAIN_W = 4 * OFS_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAIN_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       wordCnt;
  methodT           pinMethod;
  logic             active;

  assign pinMethod = decodeMethod(modeSel, {selHiSerEnN, selLoSerData});
  assign active    = mrstN && prstN && !progDone;

  always_comb begin
    strb            = '0;
    strb.presetSel  = {selHiSerEnN, selLoSerData};
    strb.wordIdx    = wordCnt;
    strb.clearAll   = !mrstN && (pinMethod != METH_PRESET);
    strb.loadPreset = !mrstN && (pinMethod == METH_PRESET);
    strb.shiftIn    = active && (methodQ == METH_SERIAL) && !selHiSerEnN;
    strb.wordWr     = active && (methodQ == METH_PARALLEL) && hostLoad;
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      methodQ  <= pinMethod;
      bitCnt   <= '0;
      wordCnt  <= '0;
      progDone <= (pinMethod == METH_PRESET);
    end else begin
      if (strb.shiftIn) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) progDone <= 1'b1;
      end
      if (strb.wordWr) begin
        wordCnt <= wordCnt + 1'b1;
        if (wordCnt == 2'd3) progDone <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flagOffsetData.sv
`timescale 1ns/1ps
module flagOffsetData
  import flagOffsetPkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  ofsStrbT          strb,
  input  logic             serData,
  input  logic [OFS_W-1:0] hostOfs,
  output logic [OFS_W-1:0] slotVal [4]
);
  localparam int CHAIN_W = 4 * OFS_W;

  logic [CHAIN_W-1:0] chainQ;
  logic [OFS_W-1:0]   presetVal;

  always_comb begin
    unique case (strb.presetSel)
      2'b00:   presetVal = OFS_W'(64);
      2'b01:   presetVal = OFS_W'(16);
      default: presetVal = OFS_W'(8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.clearAll)        chainQ <= '0;
    else if (strb.loadPreset) chainQ <= {4{presetVal}};
    else if (strb.shiftIn)    chainQ <= {chainQ[CHAIN_W-2:0], serData};
    else if (strb.wordWr)
      chainQ[CHAIN_W - 1 - int'(strb.wordIdx) * OFS_W -: OFS_W] <= hostOfs;
  end

  // slot 0 is Y1 at the chain head, slot 3 is X2 at the tail
  for (genvar k = 0; k < 4; k++) begin : g_slot
    assign slotVal[k] = chainQ[CHAIN_W - 1 - k * OFS_W -: OFS_W];
  end

endmodule

// File: rtl/flagOffsetProg.sv
`timescale 1ns/1ps
module flagOffsetProg
  import flagOffsetPkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             modeSel,
  input  logic             selHiSerEnN,
  input  logic             selLoSerData,
  input  logic [OFS_W-1:0] hostOfs,
  input  logic             hostLoad,
  output logic [OFS_W-1:0] ofsY1,
  output logic [OFS_W-1:0] ofsX1,
  output logic [OFS_W-1:0] ofsY2,
  output logic [OFS_W-1:0] ofsX2,
  output logic             progDone
);
  methodT           methodQ;
  ofsStrbT          strb;
  logic [OFS_W-1:0] slotVal [4];

  flagOffsetCtrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk          (clk),
    .mrstN        (mrstN),
    .prstN        (prstN),
    .modeSel      (modeSel),
    .selHiSerEnN  (selHiSerEnN),
    .selLoSerData (selLoSerData),
    .hostLoad     (hostLoad),
    .methodQ      (methodQ),
    .strb         (strb),
    .progDone     (progDone)
  );

  flagOffsetData #(.OFS_W(OFS_W)) u_data (
    .clk     (clk),
    .strb    (strb),
    .serData (selLoSerData),
    .hostOfs (hostOfs),
    .slotVal (slotVal)
  );

  assign ofsY1 = slotVal[0];
  assign ofsX1 = slotVal[1];
  assign ofsY2 = slotVal[2];
  assign ofsX2 = slotVal[3];

endmodule

// File: rtl/flagOffsetProgChk.sv
`timescale 1ns/1ps
module flagOffsetProgChk
  import flagOffsetPkg::*;
#(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             mrstN,
  input logic             prstN,
  input logic             selHiSerEnN,
  input logic             selLoSerData,
  input logic [OFS_W-1:0] hostOfs,
  input logic             hostLoad,
  input logic [OFS_W-1:0] ofsY1,
  input logic [OFS_W-1:0] ofsX1,
  input logic [OFS_W-1:0] ofsY2,
  input logic [OFS_W-1:0] ofsX2,
  input logic             progDone,
  input methodT           methodQ
);

  a_r1_method_held: assert property (@(posedge clk) disable iff (!mrstN)
    1'b1 |=> $stable(methodQ));

  a_r2_preset_done: assert property (@(posedge clk) disable iff (!mrstN)
    (methodQ == METH_PRESET) |-> progDone);

  a_r4_shift_tail: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && !progDone && methodQ == METH_SERIAL && !selHiSerEnN)
    |=> ofsX2[0] == $past(selLoSerData));

  a_r5_shift_head: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && !progDone && methodQ == METH_SERIAL && !selHiSerEnN)
    |=> ofsY1 == {$past(ofsY1[OFS_W-2:0]), $past(ofsX1[OFS_W-1])});

  a_r6_word_lands: assert property (@(posedge clk) disable iff (!mrstN)
    (prstN && !progDone && methodQ == METH_PARALLEL && hostLoad)
    |=> (ofsY1 == $past(hostOfs)) || (ofsX1 == $past(hostOfs)) ||
        (ofsY2 == $past(hostOfs)) || (ofsX2 == $past(hostOfs)));

  a_r7_done_frozen: assert property (@(posedge clk) disable iff (!mrstN)
    progDone |=> progDone && $stable(ofsY1) && $stable(ofsX1) &&
                 $stable(ofsY2) && $stable(ofsX2));

  a_r8_partial_hold: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> $stable(progDone) && $stable(ofsY1) && $stable(ofsX1) &&
               $stable(ofsY2) && $stable(ofsX2));

endmodule

bind flagOffsetProg flagOffsetProgChk #(.OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .mrstN        (mrstN),
  .prstN        (prstN),
  .selHiSerEnN  (selHiSerEnN),
  .selLoSerData (selLoSerData),
  .hostOfs      (hostOfs),
  .hostLoad     (hostLoad),
  .ofsY1        (ofsY1),
  .ofsX1        (ofsX1),
  .ofsY2        (ofsY2),
  .ofsX2        (ofsX2),
  .progDone     (progDone),
  .methodQ      (methodQ)
);

// File: tb/flagOffsetProg_bench.sv
`timescale 1ns/1ps
module flagOffsetProg_bench;
  localparam int W = 8;
  localparam logic [4*W-1:0] PAT = 32'hA5C3_1E96;

  // {modeSel, sel1, sel0, expected offset[9:0], expected done}
  localparam logic [13:0] TBL [6] = '{
    {3'b000, 10'd0,  1'b0},
    {3'b100, 10'd64, 1'b1},
    {3'b101, 10'd16, 1'b1},
    {3'b111, 10'd0,  1'b0},
    {3'b110, 10'd8,  1'b1},
    {3'b011, 10'd0,  1'b0}
  };

  logic clk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, modeSel = 1'b0;
  logic selHi = 1'b0, selLo = 1'b0, hostLoad = 1'b0;
  logic [W-1:0] hostOfs = '0;
  logic [W-1:0] ofsY1, ofsX1, ofsY2, ofsX2;
  logic progDone;
  int nChecks = 0, nFail = 0;

  always #4 clk = ~clk;

  flagOffsetProg #(.OFS_W(W)) u_flagOffsetProg (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .selHiSerEnN(selHi), .selLoSerData(selLo), .hostOfs(hostOfs),
    .hostLoad(hostLoad), .ofsY1(ofsY1), .ofsX1(ofsX1), .ofsY2(ofsY2),
    .ofsX2(ofsX2), .progDone(progDone));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [W-1:0] y1, x1, y2, x2, input logic dn);
    chk({req, " Y1"}, 32'(ofsY1), 32'(y1));
    chk({req, " X1"}, 32'(ofsX1), 32'(x1));
    chk({req, " Y2"}, 32'(ofsY2), 32'(y2));
    chk({req, " X2"}, 32'(ofsX2), 32'(x2));
    chk({req, " done"}, 32'(progDone), 32'(dn));
  endtask

  task automatic doReset(input logic m, input logic s1, input logic s0);
    @(negedge clk);
    mrstN = 1'b0; modeSel = m; selHi = s1; selLo = s0;
    repeat (4) @(negedge clk);
    mrstN = 1'b1; selHi = 1'b1; selLo = 1'b0;
    @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    selHi = 1'b0; selLo = b;
    @(negedge clk);
    selHi = 1'b1;
  endtask

  task automatic loadWord(input logic [W-1:0] v);
    hostOfs = v; hostLoad = 1'b1;
    @(negedge clk);
    hostLoad = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkAll("R3 in reset", '0, '0, '0, '0, 1'b0);

    // R1 R2 R3 R9: method table walked across back-to-back master resets
    for (int i = 0; i < 6; i++) begin
      doReset(TBL[i][13], TBL[i][12], TBL[i][11]);
      chkAll("R1/R2/R3/R9 table", W'(TBL[i][10:1]), W'(TBL[i][10:1]),
             W'(TBL[i][10:1]), W'(TBL[i][10:1]), TBL[i][0]);
    end

    // R4 R5 R8 R7: serial chain
    doReset(1'b0, 1'b0, 1'b0);
    shiftBit(PAT[4*W-1]);
    chk("R4 first bit at X2 lsb", 32'(ofsX2), 32'(PAT[4*W-1]));
    repeat (3) @(negedge clk);
    chk("R4 enable high holds", 32'(ofsX2), 32'(PAT[4*W-1]));
    prstN = 1'b0; selHi = 1'b0; selLo = 1'b0;
    repeat (2) @(negedge clk);
    prstN = 1'b1; selHi = 1'b1;
    chk("R8 no shift in partial reset", 32'(ofsX2), 32'(PAT[4*W-1]));
    for (int b = 4*W-2; b >= 1; b--) shiftBit(PAT[b]);
    chk("R5 done low before last bit", 32'(progDone), 32'd0);
    shiftBit(PAT[0]);
    chkAll("R5 chain order", PAT[31:24], PAT[23:16], PAT[15:8], PAT[7:0], 1'b1);
    for (int b = 0; b < 3; b++) shiftBit(1'b1);
    chkAll("R7 serial after done", PAT[31:24], PAT[23:16], PAT[15:8], PAT[7:0], 1'b1);

    // R6 R8 R7: parallel words
    doReset(1'b1, 1'b1, 1'b1);
    loadWord(8'h11);
    chkAll("R6 first word", 8'h11, 8'h00, 8'h00, 8'h00, 1'b0);
    prstN = 1'b0;
    loadWord(8'h77);
    prstN = 1'b1;
    chkAll("R8 strobe in partial reset", 8'h11, 8'h00, 8'h00, 8'h00, 1'b0);
    loadWord(8'h22);
    loadWord(8'h33);
    chk("R6 done low after three", 32'(progDone), 32'd0);
    loadWord(8'h44);
    chkAll("R6 four words", 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
    loadWord(8'h55);
    chkAll("R7 strobe after done", 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
    prstN = 1'b0;
    repeat (2) @(negedge clk);
    prstN = 1'b1;
    chkAll("R8 partial keeps values", 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);

    // R3 R9: master reset into serial clears a finished parallel set
    mrstN = 1'b0; modeSel = 1'b0; selHi = 1'b0;
    repeat (2) @(negedge clk);
    chkAll("R3 clear during reset", '0, '0, '0, '0, 1'b0);
    doReset(1'b1, 1'b0, 1'b1);
    chkAll("R9 reselect preset 16", 8'd16, 8'd16, 8'd16, 8'd16, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule